// File: doc/BRIEF.md
# Shadow Word Store Access Port

This block gives a host a way to read and write a small array of 16-bit configuration words through two 32-bit registers. The host first places a word address and a direction flag in the control register. For a store, it also places the value in the low half of the data register. It then writes the control register again with the go bit set. The block runs exactly one access after a fixed latency. It then drops the go bit and raises the finished bit. After a load, the host finds the word in the high half of the data register.

A third register position accepts a software reset command. The command puts the control register back to its idle value and cancels any access that is still pending. The word array is cleared by the hardware reset only. Four fixed word addresses always read as zero: 0x17, 0x18, 0x2D and 0x2E. Stores to them are dropped. Addresses at or above the array depth behave the same way.

The host port is a plain valid/write/select/data interface. Host writes take effect at the clock edge. Host reads are combinational on the select lines and have no side effects.

Top module: `shadow_word_port`

## Requirements
- R1: After hardware reset, the control register (select 0) reads 0x0000_0004 (only the finished bit, bit 2, is set), the data register (select 1) reads 0, and every word loads as 0.
- R2: A control write with the go bit (bit 0) clear stores the address field (bits 15:4) and the direction flag (bit 1), leaves the finished bit as it was, and changes no word.
- R3: A control write with bit 0 set while idle starts an access. The finished bit reads 0 after that edge and after the next one. After the second edge, the control register reads address<<4 | direction<<1 | 0x4.
- R4: With the direction flag set, the access stores bits 15:0 of the data register, as they were when the access started, at the addressed word.
- R5: With the direction flag clear, the access replaces bits 31:16 of the data register with the addressed word and keeps bits 15:0.
- R6: Word addresses 0x17, 0x18, 0x2D and 0x2E always load as zero, even after a store to them.
- R7: A control write that arrives while an access is pending is ignored. The control register keeps its fields and no second access runs.
- R8: A write to select 2 with bit 0 set leaves the control register reading 0x0000_0004, cancels a pending access, and leaves the words and the data register unchanged.
- R9: An address at or above the array depth loads as zero, and a store to it changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = register write, 0 = read |
| host_addr | input | 2 | Register select: 0 control, 1 data, 2 software reset |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Register read value for the selected register |

## Verification
The bench builds the block with a 64-word array and a latency of 2. At that size, one pass can store and reload every word address. This covers all four fixed-zero addresses, the aliasing boundary at address 64, and the top of the 12-bit address field, all within a short run. The latency of 2 is the smallest value that leaves a pending window wide enough to land a second go write and a software reset inside it.

// File: rtl/shadow_word_pkg.sv
package shadow_word_pkg;
  localparam int REG_W      = 32;
  localparam int WORD_W     = 16;
  localparam int SEL_W      = 2;
  localparam int CADDR_LSB  = 4;
  localparam int CADDR_W    = 12;
  localparam int BIT_GO     = 0;
  localparam int BIT_DIR    = 1;
  localparam int BIT_FIN    = 2;
  localparam int RD_LSB     = 16;
  localparam int WR_LSB     = 0;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_SWRST = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  function automatic logic is_hardwired(input logic [CADDR_W-1:0] a);
    return (a == 12'h017) || (a == 12'h018) || (a == 12'h02D) || (a == 12'h02E);
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(input logic [CADDR_W-1:0] a,
                                                 input logic dir,
                                                 input logic fin,
                                                 input logic go);
    logic [REG_W-1:0] v;
    v = '0;
    v[CADDR_LSB +: CADDR_W] = a;
    v[BIT_DIR] = dir;
    v[BIT_FIN] = fin;
    v[BIT_GO]  = go;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] merge_load(input logic [REG_W-1:0] d,
                                                  input logic [WORD_W-1:0] w);
    logic [REG_W-1:0] v;
    v = d;
    v[RD_LSB +: WORD_W] = w;
    return v;
  endfunction
endpackage

// File: rtl/shadow_word_store.sv
module shadow_word_store
  import shadow_word_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rd_word
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              in_range;
  logic              fixed_zero;
  logic              store_hit;
  logic [IW-1:0]     idx;

  assign in_range   = ({1'b0, addr} < (CADDR_W+1)'(DEPTH));
  assign fixed_zero = is_hardwired(addr);
  assign idx        = addr[IW-1:0];
  assign store_hit  = wr_en && in_range && !fixed_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (store_hit) begin
      mem[idx] <= wdata;
    end
  end

  assign rd_word = (in_range && !fixed_zero) ? mem[idx] : '0;

  // R4: a store lands in the addressed word
  assert_store_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_hit |=> mem[$past(idx)] == $past(wdata));
endmodule

// File: rtl/shadow_word_seq.sv
module shadow_word_seq #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic abort,
  output logic busy,
  output logic fire
);
  localparam int CW = (LAT > 1) ? $clog2(LAT + 1) : 1;

  logic [CW-1:0] cnt;

  assign fire = busy && (cnt == '0) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3: an accepted launch keeps the sequencer pending on the next cycle
  assert_launch_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy && !abort) |=> busy);

  // R8: an abort always leaves the sequencer idle
  assert_abort_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
endmodule

// File: rtl/shadow_word_port.sv
module shadow_word_port
  import shadow_word_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  input  logic             host_write,
  input  logic [SEL_W-1:0] host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata
);
  reg_sel_e sel;
  logic     wr_ctrl, wr_data, swrst, go_req, launch;
  logic     busy, fire;

  logic [CADDR_W-1:0] ctrl_addr_q;
  logic               ctrl_dir_q, ctrl_go_q, ctrl_fin_q;
  logic [REG_W-1:0]   data_q, data_next;

  logic [CADDR_W-1:0] op_addr;
  logic               op_dir;
  logic [WORD_W-1:0]  op_wdata;
  logic [WORD_W-1:0]  rd_word;
  logic               store_en, load_done;

  assign sel     = reg_sel_e'(host_addr);
  assign wr_ctrl = host_valid && host_write && (sel == SEL_CTRL);
  assign wr_data = host_valid && host_write && (sel == SEL_DATA);
  assign swrst   = host_valid && host_write && (sel == SEL_SWRST) && host_wdata[0];
  assign go_req  = wr_ctrl && host_wdata[BIT_GO];
  assign launch  = go_req && !busy && !swrst;

  shadow_word_seq #(.LAT(LAT)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .abort  (swrst),
    .busy   (busy),
    .fire   (fire)
  );

  assign store_en  = fire && op_dir;
  assign load_done = fire && !op_dir;

  shadow_word_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_en),
    .addr    (op_addr),
    .wdata   (op_wdata),
    .rd_word (rd_word)
  );

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_addr_q <= '0;
      ctrl_dir_q  <= 1'b0;
      ctrl_go_q   <= 1'b0;
      ctrl_fin_q  <= 1'b1;
    end else if (swrst) begin
      ctrl_addr_q <= '0;
      ctrl_dir_q  <= 1'b0;
      ctrl_go_q   <= 1'b0;
      ctrl_fin_q  <= 1'b1;
    end else if (fire) begin
      ctrl_go_q  <= 1'b0;
      ctrl_fin_q <= 1'b1;
    end else if (wr_ctrl && !busy) begin
      ctrl_addr_q <= host_wdata[CADDR_LSB +: CADDR_W];
      ctrl_dir_q  <= host_wdata[BIT_DIR];
      ctrl_go_q   <= host_wdata[BIT_GO];
      if (host_wdata[BIT_GO]) ctrl_fin_q <= 1'b0;
    end
  end

  // operands captured when an access starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr  <= '0;
      op_dir   <= 1'b0;
      op_wdata <= '0;
    end else if (launch) begin
      op_addr  <= host_wdata[CADDR_LSB +: CADDR_W];
      op_dir   <= host_wdata[BIT_DIR];
      op_wdata <= data_q[WR_LSB +: WORD_W];
    end
  end

  // data register: host write first, load result overrides the high half
  always_comb begin
    data_next = data_q;
    if (wr_data)   data_next = host_wdata;
    if (load_done) data_next = merge_load(data_next, rd_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_next;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: host_rdata = ctrl_pack(ctrl_addr_q, ctrl_dir_q, ctrl_fin_q, ctrl_go_q);
      SEL_DATA: host_rdata = data_q;
      default:  host_rdata = '0;
    endcase
  end

  // R3: finished is low right after an accepted go write
  assert_fin_low_after_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !ctrl_fin_q);

  // R3: completion drops go and raises finished
  assert_fire_completes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !swrst) |=> (ctrl_fin_q && !ctrl_go_q));

  // R2: a control write without go starts nothing
  assert_no_go_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !host_wdata[BIT_GO] && !busy) |=> !busy);

  // R5: a load keeps the low half of the data register
  assert_load_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !wr_data) |=> data_q[WR_LSB +: WORD_W] == $past(data_q[WR_LSB +: WORD_W]));

  // R6: a load from a fixed-zero address yields zero
  assert_fixed_zero_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && is_hardwired(op_addr)) |=> data_q[RD_LSB +: WORD_W] == '0);

  // R7: control writes during a pending access leave the address field alone
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && !swrst) |=> ctrl_addr_q == $past(ctrl_addr_q));

  // R8: software reset returns control to the idle value
  assert_swrst_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (ctrl_fin_q && !ctrl_go_q && ctrl_addr_q == '0 && !ctrl_dir_q));
endmodule

// File: tb/shadow_word_port_tb.sv
`timescale 1ns/1ps
module shadow_word_port_tb;
  localparam int DEPTH = 64;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  shadow_word_port #(.DEPTH(DEPTH), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [15:0] pattern(input int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF);
  endfunction

  function automatic logic fixed(input int a);
    return (a == 23) || (a == 24) || (a == 45) || (a == 46);
  endfunction

  function automatic logic [31:0] ctrl_exp(input int a, input logic dir);
    return (32'(a) << 4) | (32'(dir) << 1) | 32'h4;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = s; host_wdata = v;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [31:0] v);
    host_addr = s;
    #0.1;
    v = host_rdata;
  endtask

  // go write, check finished timing (R3), return at the negedge after completion
  task automatic run_op(input int a, input logic dir);
    logic [31:0] v;
    reg_wr(2'd0, (32'(a) << 4) | (32'(dir) << 1) | 32'h1);
    reg_rd(2'd0, v);
    check("R3 fin low edge1", {31'd0, v[2]}, 32'd0);
    @(negedge clk);
    reg_rd(2'd0, v);
    check("R3 fin low edge2", {31'd0, v[2]}, 32'd0);
    @(negedge clk);
    reg_rd(2'd0, v);
    check("R3 ctrl after completion", v, ctrl_exp(a, dir));
  endtask

  task automatic store_word(input int a, input logic [15:0] w);
    reg_wr(2'd1, {16'h0000, w});
    run_op(a, 1'b1);
  endtask

  task automatic load_word(input int a, input logic [15:0] marker, output logic [31:0] v);
    reg_wr(2'd1, {16'hFFFF, marker});
    run_op(a, 1'b0);
    reg_rd(2'd1, v);
  endtask

  initial begin
    #(4 * 200000);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    reg_rd(2'd0, v); check("R1 ctrl reset", v, 32'h4);
    reg_rd(2'd1, v); check("R1 data reset", v, 32'h0);
    for (int a = 0; a < DEPTH; a++) begin
      load_word(a, 16'h1111, v);
      check("R1 word zero", v, {16'h0000, 16'h1111});
    end

    // R2
    reg_wr(2'd1, 32'h0000_BEEF);
    reg_wr(2'd0, (32'd5 << 4) | 32'h2);
    reg_rd(2'd0, v); check("R2 ctrl fields no go", v, ctrl_exp(5, 1'b1));
    repeat (3) @(negedge clk);
    load_word(5, 16'h2222, v);
    check("R2 no store without go", v, {16'h0000, 16'h2222});

    // R4 sweep, then R5/R6 readback
    for (int a = 0; a < DEPTH; a++) store_word(a, pattern(a));
    for (int a = 0; a < DEPTH; a++) begin
      load_word(a, 16'(a ^ 16'h5A5A), v);
      if (fixed(a)) check("R6 fixed zero", v, {16'h0000, 16'(a ^ 16'h5A5A)});
      else          check("R4 R5 stored word", v, {pattern(a), 16'(a ^ 16'h5A5A)});
    end

    // R9
    store_word(64, 16'hDEAD);
    store_word(4095, 16'hCAFE);
    load_word(64, 16'h3333, v);   check("R9 addr 64 zero", v, {16'h0000, 16'h3333});
    load_word(4095, 16'h3333, v); check("R9 addr 4095 zero", v, {16'h0000, 16'h3333});
    load_word(0, 16'h3333, v);    check("R9 no alias to 0", v, {pattern(0), 16'h3333});
    load_word(63, 16'h3333, v);   check("R9 no alias to 63", v, {pattern(63), 16'h3333});

    // R7: go while pending
    reg_wr(2'd1, 32'h0000_7777);
    reg_wr(2'd0, (32'd3 << 4) | 32'h1);
    reg_wr(2'd0, (32'd7 << 4) | 32'h3);
    @(negedge clk);
    reg_rd(2'd0, v); check("R7 ctrl keeps first op", v, ctrl_exp(3, 1'b0));
    reg_rd(2'd1, v); check("R7 first load result", v, {pattern(3), 16'h7777});
    repeat (4) @(negedge clk);
    reg_rd(2'd0, v); check("R7 no second op", v, ctrl_exp(3, 1'b0));
    load_word(7, 16'h4444, v); check("R7 word 7 unchanged", v, {pattern(7), 16'h4444});

    // R8: software reset cancels pending store
    reg_wr(2'd1, 32'h0000_9999);
    reg_wr(2'd0, (32'd9 << 4) | 32'h3);
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd0, v); check("R8 ctrl idle", v, 32'h4);
    reg_rd(2'd1, v); check("R8 data kept", v, 32'h0000_9999);
    repeat (4) @(negedge clk);
    reg_rd(2'd0, v); check("R8 still idle", v, 32'h4);
    load_word(9, 16'h5555, v); check("R8 store cancelled", v, {pattern(9), 16'h5555});

    done_run = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule